// File: doc/BRIEF.md
# Thermostat Alert with Fault Queue

This block watches the stream of temperature results from a sensor converter. Each result is a 13-bit two's-complement value that arrives with a one-cycle strobe. The block compares each result against a programmable upper trip limit and a programmable lower release limit. A result only counts once it has been seen a set number of times in a row, so a single noisy sample cannot trip or release the alert.

There are three ways the alert can behave. A thermostat-style mode follows the temperature with hysteresis. An event mode raises the alert once per crossing, alternating between upper and lower crossings, and a register read acknowledges it. A latched mode trips like the thermostat mode, but it releases only after the temperature has cooled and the host has then touched the serial port. A polarity bit selects the level of the single alert output. The surrounding logic supplies the limits, the mode and queue settings, and the read, access and shutdown pulses.

Top module: `thermo_alert`

## Requirements
- R1: The queue setting `fault_sel` selects how many consecutive qualifying results are required: 2'b00 needs 1, 2'b01 needs 2, 2'b10 needs 4 and 2'b11 needs 6.
- R2: If a result fails the condition currently being counted, the consecutive count starts again from zero.
- R3: In mode 2'b00, and in the spare code 2'b11, the alert becomes active after N consecutive results at or above `lim_hi`. It becomes inactive after N consecutive results strictly below `lim_lo`.
- R4: In mode 2'b01, the alert becomes active after N consecutive results at or above `lim_hi`. It stays active, whatever the temperature, until a `reg_read` pulse, which makes it inactive on the next cycle.
- R5: In mode 2'b01, after an upper event the next event is N consecutive results below `lim_lo`. The upper limit cannot raise the alert until a lower event has fired, and after the lower event the block looks for an upper event again.
- R6: While `shutdown` is high, conversion strobes are ignored and the consecutive count restarts. In mode 2'b01, shutdown also makes the alert inactive without changing which limit is armed next.
- R7: In mode 2'b10, the alert trips as in R3. After N consecutive results below `lim_lo`, it stays active until a `bus_access` pulse in a later cycle. A `bus_access` pulse before that point has no effect.
- R8: With `polarity`=0 the `alert` pin is low when the alert is active. With `polarity`=1 the pin is high when the alert is active. The pin follows `polarity` combinationally.
- R9: The comparisons are signed over all 13 bits, including the low-order bits. A result equal to `lim_hi` trips, and a result equal to `lim_lo` does not release.
- R10: The count advances only on cycles where `conv_valid` is high. A steady input with no strobe changes nothing.
- R11: After reset the alert is inactive, the upper limit is armed and the count is zero. With polarity 0 the pin reads high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| conv_valid | input | 1 | One-cycle strobe marking a new result |
| conv_temp | input | 13 | Signed result |
| lim_hi | input | 13 | Signed upper trip limit |
| lim_lo | input | 13 | Signed lower release limit |
| mode | input | 2 | Alert mode: 00 thermostat, 01 event, 10 latched, 11 as 00 |
| fault_sel | input | 2 | Consecutive-result count select |
| polarity | input | 1 | Active level of `alert` |
| reg_read | input | 1 | Pulse: a register was read |
| bus_access | input | 1 | Pulse: a serial transaction occurred |
| shutdown | input | 1 | Converter shut down |
| alert | output | 1 | Alert level |

## Verification
The bench sweeps every queue setting in both thermostat codes and feeds exactly N-1 and then N qualifying results. An off-by-one in the count would therefore trip one result early or late. Interrupted runs check that the count restarts instead of accumulating. Boundary values exactly at each limit, negative limits and a one-LSB limit offset catch an unsigned or truncated comparison. The event-mode sequence checks that the alert alternates between limits and survives shutdown with the correct limit still armed; a design that re-armed the upper limit would trip on heat after an acknowledge. The latched mode is probed with an early access pulse, which must not release a still-hot alert.

// File: rtl/thermo_alert_pkg.sv
package thermo_alert_pkg;

    typedef enum logic [1:0] {
        MODE_CMP  = 2'b00,
        MODE_INT  = 2'b01,
        MODE_INTC = 2'b10,
        MODE_RSV  = 2'b11
    } alert_mode_e;

    typedef struct packed {
        logic active;       // logical alert state
        logic seek_low;     // event mode: next event is a low crossing
        logic release_pend; // latched mode: cooled, waiting for an access
    } alert_state_t;

    localparam int QCNT_W = 3;

    function automatic logic [QCNT_W-1:0] fault_need(input logic [1:0] sel);
        logic [QCNT_W-1:0] n;
        case (sel)
            2'b00:   n = QCNT_W'(1);
            2'b01:   n = QCNT_W'(2);
            2'b10:   n = QCNT_W'(4);
            default: n = QCNT_W'(6);
        endcase
        return n;
    endfunction

endpackage

// File: rtl/thm_limit_cmp.sv
module thm_limit_cmp #(
    parameter int TW = 13
) (
    input  logic [TW-1:0] temp,
    input  logic [TW-1:0] hi,
    input  logic [TW-1:0] lo,
    output logic          hot,
    output logic          cold
);
    always_comb begin
        hot  = ($signed(temp) >= $signed(hi));
        cold = ($signed(temp) <  $signed(lo));
    end
endmodule

// File: rtl/thm_fault_queue.sv
module thm_fault_queue #(
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step,
    input  logic             hit,
    input  logic             clear,
    input  logic [CNT_W-1:0] need,
    output logic             fire
);
    localparam int SUM_W = CNT_W + 1;

    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic [SUM_W-1:0] next_run;

    always_comb begin
        next_run = {1'b0, cnt_q} + SUM_W'(1);
        fire     = step && hit && (next_run >= {1'b0, need});
        cnt_d    = cnt_q;
        if (clear) begin
            cnt_d = '0;
        end else if (step) begin
            if (!hit || fire) cnt_d = '0;
            else              cnt_d = next_run[CNT_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // R2: a failing result restarts the run
    p_miss_restarts_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !hit) |=> (cnt_q == '0));

    // R10: no strobe, no movement
    p_hold_without_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!step && !clear) |=> $stable(cnt_q));

endmodule

// File: rtl/thermo_alert.sv
module thermo_alert
    import thermo_alert_pkg::*;
#(
    parameter int TW = 13
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          conv_valid,
    input  logic [TW-1:0] conv_temp,
    input  logic [TW-1:0] lim_hi,
    input  logic [TW-1:0] lim_lo,
    input  logic [1:0]    mode,
    input  logic [1:0]    fault_sel,
    input  logic          polarity,
    input  logic          reg_read,
    input  logic          bus_access,
    input  logic          shutdown,
    output logic          alert
);
    alert_state_t st_q, st_d;
    alert_mode_e  eff_mode;
    logic         hot, cold;
    logic         count_en, hit, step, fire;

    thm_limit_cmp #(.TW(TW)) u_cmp (
        .temp (conv_temp),
        .hi   (lim_hi),
        .lo   (lim_lo),
        .hot  (hot),
        .cold (cold)
    );

    always_comb begin
        eff_mode = alert_mode_e'(mode);
        if (eff_mode == MODE_RSV) eff_mode = MODE_CMP;
        case (eff_mode)
            MODE_INT: begin
                hit      = st_q.seek_low ? cold : hot;
                count_en = !st_q.active;
            end
            default: begin
                hit      = st_q.active ? cold : hot;
                count_en = !st_q.release_pend;
            end
        endcase
        step = conv_valid && !shutdown && count_en;
    end

    thm_fault_queue #(.CNT_W(QCNT_W)) u_queue (
        .clk   (clk),
        .rst_n (rst_n),
        .step  (step),
        .hit   (hit),
        .clear (shutdown),
        .need  (fault_need(fault_sel)),
        .fire  (fire)
    );

    always_comb begin
        st_d = st_q;
        case (eff_mode)
            MODE_INT: begin
                if (reg_read || shutdown) st_d.active = 1'b0;
                if (fire) begin
                    st_d.active   = 1'b1;
                    st_d.seek_low = !st_q.seek_low;
                end
            end
            MODE_INTC: begin
                if (st_q.release_pend && bus_access) begin
                    st_d.active       = 1'b0;
                    st_d.release_pend = 1'b0;
                end else if (fire) begin
                    if (!st_q.active) st_d.active       = 1'b1;
                    else              st_d.release_pend = 1'b1;
                end
            end
            default: begin
                st_d.release_pend = 1'b0;
                if (fire) st_d.active = !st_q.active;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign alert = polarity ? st_q.active : !st_q.active;

    // R1: the alert never rises without a completed run
    p_rise_needs_run_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.active && !fire) |=> !st_q.active);

    // R4: a read acknowledges an event-mode alert
    p_read_acks_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (eff_mode == MODE_INT && reg_read && !fire) |=> !st_q.active);

    // R6: shutdown clears an event-mode alert
    p_sd_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (eff_mode == MODE_INT && shutdown) |=> !st_q.active);

    // R7: latched alert holds without an access
    p_latched_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (eff_mode == MODE_INTC && st_q.active && !bus_access) |=> st_q.active);

endmodule

// File: tb/thermo_alert_test.sv
`timescale 1ns/1ps
module thermo_alert_test;
    localparam int TW = 13;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          conv_valid = 1'b0;
    logic [TW-1:0] conv_temp = '0;
    logic [TW-1:0] lim_hi = TW'(1280);
    logic [TW-1:0] lim_lo = TW'(1200);
    logic [1:0]    mode = 2'b00;
    logic [1:0]    fault_sel = 2'b00;
    logic          polarity = 1'b0;
    logic          reg_read = 1'b0;
    logic          bus_access = 1'b0;
    logic          shutdown = 1'b0;
    logic          alert;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    localparam int HOT  = 1300;
    localparam int MID  = 1240;
    localparam int COLD = 1100;

    thermo_alert #(.TW(TW)) uut (
        .clk(clk), .rst_n(rst_n), .conv_valid(conv_valid), .conv_temp(conv_temp),
        .lim_hi(lim_hi), .lim_lo(lim_lo), .mode(mode), .fault_sel(fault_sel),
        .polarity(polarity), .reg_read(reg_read), .bus_access(bus_access),
        .shutdown(shutdown), .alert(alert)
    );

    always #5 clk = ~clk;

    task automatic check_active(input bit exp_active, input string tag);
        logic exp_pin;
        exp_pin = polarity ? exp_active : !exp_active;
        n_tests++;
        if (alert !== exp_pin) begin
            n_fail++;
            $display("FAIL %s: alert=%b expected %b (t=%0t)", tag, alert, exp_pin, $time);
        end
    endtask

    task automatic conv(input int t);
        @(negedge clk);
        conv_valid = 1'b1;
        conv_temp  = TW'(t);
        @(negedge clk);
        conv_valid = 1'b0;
    endtask

    task automatic conv_n(input int t, input int n);
        for (int i = 0; i < n; i++) conv(t);
    endtask

    task automatic pulse_read();
        @(negedge clk); reg_read = 1'b1;
        @(negedge clk); reg_read = 1'b0;
    endtask

    task automatic pulse_access();
        @(negedge clk); bus_access = 1'b1;
        @(negedge clk); bus_access = 1'b0;
    endtask

    function automatic int need_of(input int f);
        return (f == 0) ? 1 : (f == 1) ? 2 : (f == 2) ? 4 : 6;
    endfunction

    initial begin
        #2_000_000;
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: run did not complete");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check_active(1'b0, "R11 pin high in reset, pol 0");
        rst_n = 1'b1;
        @(negedge clk);
        check_active(1'b0, "R11 inactive after reset");
        n_tests++;
        if (alert !== 1'b1) begin n_fail++; $display("FAIL R11: alert=%b expected 1", alert); end
        polarity = 1'b1;
        #1;
        n_tests++;
        if (alert !== 1'b0) begin n_fail++; $display("FAIL R8: alert=%b expected 0", alert); end

        // R1 / R3 sweep over queue depth and both thermostat codes
        for (int m = 0; m < 2; m++) begin
            for (int f = 0; f < 4; f++) begin
                int n;
                n = need_of(f);
                mode = (m == 0) ? 2'b00 : 2'b11;
                fault_sel = 2'(f);
                conv_n(HOT, n - 1);
                check_active(1'b0, "R1 one short of run");
                conv(HOT);
                check_active(1'b1, "R3 trip after N hot");
                conv_n(COLD, n - 1);
                check_active(1'b1, "R3 hold one short of release");
                conv(COLD);
                check_active(1'b0, "R3 release after N cold");
                if (n > 1) begin
                    conv_n(HOT, n - 1);
                    conv(MID);
                    conv_n(HOT, n - 1);
                    check_active(1'b0, "R2 interrupted run restarts");
                    conv(HOT);
                    check_active(1'b1, "R2 full run after restart");
                    conv_n(COLD, n - 1);
                    conv(HOT);
                    conv_n(COLD, n - 1);
                    check_active(1'b1, "R2 interrupted cold run");
                    conv(COLD);
                    check_active(1'b0, "R2 release after full cold run");
                end
            end
        end

        // R10: no strobe, no count
        mode = 2'b00; fault_sel = 2'b00;
        @(negedge clk);
        conv_temp = TW'(HOT);
        repeat (10) @(negedge clk);
        check_active(1'b0, "R10 no strobe no trip");

        // R9: boundaries, low bits, signs
        lim_hi = TW'(1281);
        conv(1280);
        check_active(1'b0, "R9 one LSB below hi");
        conv(1281);
        check_active(1'b1, "R9 equal hi trips");
        conv(1200);
        check_active(1'b1, "R9 equal lo holds");
        conv(1199);
        check_active(1'b0, "R9 below lo releases");
        lim_hi = TW'(-8); lim_lo = TW'(-16);
        conv(5);
        check_active(1'b1, "R9 signed hi compare");
        conv(-16);
        check_active(1'b1, "R9 signed lo equal");
        conv(-17);
        check_active(1'b0, "R9 signed below lo");
        lim_hi = TW'(1280); lim_lo = TW'(1200);

        // Event mode, N=2
        mode = 2'b01; fault_sel = 2'b01;
        conv(HOT);
        check_active(1'b0, "R4 one hot not enough");
        conv(HOT);
        check_active(1'b1, "R4 trip");
        conv_n(COLD, 3);
        check_active(1'b1, "R4 held regardless of temp");
        pulse_read();
        check_active(1'b0, "R4 read clears");
        conv_n(HOT, 3);
        check_active(1'b0, "R5 hi disarmed after event");
        conv(COLD);
        check_active(1'b0, "R5 one cold not enough");
        conv(COLD);
        check_active(1'b1, "R5 low event");
        pulse_read();
        check_active(1'b0, "R5 read clears low event");
        conv_n(COLD, 2);
        check_active(1'b0, "R5 lo disarmed after low event");
        conv_n(HOT, 2);
        check_active(1'b1, "R5 re-armed hi");
        @(negedge clk); shutdown = 1'b1;
        @(negedge clk);
        check_active(1'b0, "R6 shutdown clears");
        conv_n(COLD, 3);
        check_active(1'b0, "R6 strobes ignored in shutdown");
        @(negedge clk); shutdown = 1'b0;
        conv(COLD);
        check_active(1'b0, "R6 count restarted");
        conv(COLD);
        check_active(1'b1, "R6 lo still armed after shutdown");
        pulse_read();
        check_active(1'b0, "R4 read clears again");

        // Latched mode, N=1
        mode = 2'b10; fault_sel = 2'b00;
        conv(HOT);
        check_active(1'b1, "R7 trip like thermostat");
        pulse_access();
        check_active(1'b1, "R7 early access ignored");
        conv(COLD);
        check_active(1'b1, "R7 cooled but waiting");
        repeat (5) @(negedge clk);
        check_active(1'b1, "R7 still waiting");
        polarity = 1'b0;
        #1;
        check_active(1'b1, "R8 active low pin");
        polarity = 1'b1;
        pulse_access();
        check_active(1'b0, "R7 access releases");

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule